// File: doc/BRIEF.md
# Quadrature and Edge Event Counter Timer

This block is a 16-bit event counter driven by off-chip signals. In plain mode it counts edges on phase A. In encoder mode it follows a two-phase quadrature signal on phases A and B, counting up or down. Software drives it through a small register port with one write strobe and a combinational read path. It first sets the enable bit, then loads a wrap limit and a compare value, then issues a start command. Each limit or compare load completes one clock after the write and raises a completion flag. That flag stays set until software writes a one to the matching bit of the flag-clear register.

The edge selector sets which transitions count. In plain mode, each selected edge adds one. In encoder mode, it sets the resolution: two counts per input cycle for either single-edge setting, four for both edges. The mode and edge selector are locked while the block is enabled. The wrap limit is locked once counting has started.

Top module: `lpt_enc_timer`

Register map (3-bit address): 0 control (bit0 enable, bit1 start / running), 1 setup (bit0 encoder mode, bits 2:1 edge select), 2 wrap limit, 3 compare, 4 status (bit0 limit-load done, bit1 compare-load done, bit2 direction), 5 flag clear (write 1 to bit0 / bit1), 6 count (read only).

## Requirements
- R1: After reset, the wrap limit reads 0xFFFF, the count reads 0, the compare reads 0, and status reads 0x0004 (no flags set, direction up).
- R2: Writes to the wrap-limit or compare register while enable is 0 change nothing: the readback is unchanged and no completion flag is set.
- R3: A wrap-limit write while enabled and not running is not visible on the first read after the write edge. It lands on the following edge, together with status bit0. A compare write while enabled behaves the same way and sets status bit1. A wrap-limit write while running is ignored.
- R4: A completion flag stays set until a flag-clear write carries a 1 in its bit. If that clear arrives on the same edge as a new completion of the same register, the flag remains set.
- R5: The count changes only while running. Running is set by a control write with bits 1 and 0 both high, and only while enable is already 1. A start bit given in the same write that sets enable leaves the block enabled but idle. Control reads back {running, enable}.
- R6: Setup writes (bit0 encoder mode, bits 2:1 edge select) are ignored while enable is 1.
- R7: In plain mode, phase A is counted up by one on each edge that the selector picks: 0 rising, 1 falling, 2 or 3 both.
- R8: In encoder mode, the count moves by four per input cycle with selector 2 or 3. It moves by two per cycle with selector 0 (phase A transitions) or selector 1 (phase B transitions). The count goes up when A leads B.
- R9: Counting up from the wrap limit gives 0. Counting down from 0 gives the wrap limit.
- R10: Status bit2 holds the direction of the last valid encoder step: 1 for up, 0 for down.
- R11: An encoder sample in which both phases changed is discarded. The count and the direction are unchanged.
- R12: Clearing enable stops counting and makes the count read 0 from the next edge. The wrap limit is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the addressed register |
| inA | input | 1 | Phase A / plain count input, asynchronous |
| inB | input | 1 | Phase B input, asynchronous |

## Verification
A completion flag can be set by a pending limit load and cleared by software on the same clock edge. The bench provokes this by issuing a flag-clear write on the cycle immediately after a wrap-limit write, so the clear meets the commit edge. It then judges the result from the status register, which must still show the flag. A second, isolated clear must then drop it. Disabling the block while a count value is held is also checked: the count must go to zero on the next edge.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SETUP  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CLR    = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edgeSel_e;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic     run;
    logic     zero;
    logic     encMode;
    edgeSel_e edgeSel;
  } dpCtl_t;
endpackage

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
  import lpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CW-1:0]     regWdata,
  input  logic [CW-1:0]     cntVal,
  input  logic              dirUp,
  output logic [CW-1:0]     regRdata,
  output dpCtl_t            dpCtl,
  output logic [CW-1:0]     limitVal,
  output logic [1:0]        okFlags
);
  logic enable, running, encMode;
  edgeSel_e edgeSel;
  logic [CW-1:0] cmpVal, limitShadow, cmpShadow;
  logic limitPend, cmpPend, limitOk, cmpOk;

  logic wrCtrl, wrSetup, wrLimit, wrCmp, wrClr;
  assign wrCtrl  = regWe && (regAddr == ADDR_CTRL);
  assign wrSetup = regWe && (regAddr == ADDR_SETUP);
  assign wrLimit = regWe && (regAddr == ADDR_LIMIT);
  assign wrCmp   = regWe && (regAddr == ADDR_CMP);
  assign wrClr   = regWe && (regAddr == ADDR_CLR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      running <= 1'b0;
      encMode <= 1'b0;
      edgeSel <= EDGE_RISE;
    end else begin
      if (wrCtrl) begin
        enable  <= regWdata[0];
        running <= regWdata[0] && (running || (enable && regWdata[1]));
      end
      if (wrSetup && !enable) begin
        encMode <= regWdata[0];
        edgeSel <= edgeSel_e'(regWdata[2:1]);
      end
    end
  end

  // two-step load: capture on the write edge, commit on the next
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitShadow <= '0;
      cmpShadow   <= '0;
      limitPend   <= 1'b0;
      cmpPend     <= 1'b0;
      limitVal    <= '1;
      cmpVal      <= '0;
      limitOk     <= 1'b0;
      cmpOk       <= 1'b0;
    end else begin
      limitPend <= wrLimit && enable && !running;
      cmpPend   <= wrCmp && enable;
      if (wrLimit && enable && !running) limitShadow <= regWdata;
      if (wrCmp && enable) cmpShadow <= regWdata;
      if (limitPend) limitVal <= limitShadow;
      if (cmpPend) cmpVal <= cmpShadow;
      if (limitPend) limitOk <= 1'b1;
      else if (wrClr && regWdata[0]) limitOk <= 1'b0;
      if (cmpPend) cmpOk <= 1'b1;
      else if (wrClr && regWdata[1]) cmpOk <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdata = CW'({running, enable});
      ADDR_SETUP:  regRdata = CW'({edgeSel, encMode});
      ADDR_LIMIT:  regRdata = limitVal;
      ADDR_CMP:    regRdata = cmpVal;
      ADDR_STATUS: regRdata = CW'({dirUp, cmpOk, limitOk});
      ADDR_COUNT:  regRdata = cntVal;
      default:     regRdata = '0;
    endcase
  end

  assign dpCtl.run     = running;
  assign dpCtl.zero    = !enable;
  assign dpCtl.encMode = encMode;
  assign dpCtl.edgeSel = edgeSel;
  assign okFlags       = {cmpOk, limitOk};
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inA,
  input  logic          inB,
  input  dpCtl_t        dpCtl,
  input  logic [CW-1:0] limitVal,
  output logic [CW-1:0] cntVal,
  output logic          dirUp
);
  localparam int PHASES = 2;

  logic [PHASES-1:0] phRaw, phSync, phPrev;
  assign phRaw = {inA, inB};

  for (genvar g = 0; g < PHASES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], phRaw[g]};
    end
    assign phSync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phPrev <= '0;
    else       phPrev <= phSync;
  end

  logic aNow, bNow, aPrev, bPrev, aChg, bChg, validStep, stepUp;
  assign aNow      = phSync[1];
  assign bNow      = phSync[0];
  assign aPrev     = phPrev[1];
  assign bPrev     = phPrev[0];
  assign aChg      = aNow ^ aPrev;
  assign bChg      = bNow ^ bPrev;
  assign validStep = aChg ^ bChg;
  assign stepUp    = aNow ^ bPrev;

  logic countEv, countUp;
  always_comb begin
    if (dpCtl.encMode) begin
      countUp = stepUp;
      unique case (dpCtl.edgeSel)
        EDGE_RISE: countEv = validStep && aChg;
        EDGE_FALL: countEv = validStep && bChg;
        default:   countEv = validStep;
      endcase
    end else begin
      countUp = 1'b1;
      unique case (dpCtl.edgeSel)
        EDGE_RISE: countEv = aNow && !aPrev;
        EDGE_FALL: countEv = !aNow && aPrev;
        default:   countEv = aChg;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
      dirUp  <= 1'b1;
    end else begin
      if (dpCtl.zero) begin
        cntVal <= '0;
      end else if (dpCtl.run && countEv) begin
        if (countUp) cntVal <= (cntVal >= limitVal) ? '0 : cntVal + 1'b1;
        else         cntVal <= (cntVal == '0) ? limitVal : cntVal - 1'b1;
      end
      if (dpCtl.run && dpCtl.encMode && validStep) dirUp <= stepUp;
    end
  end
endmodule

// File: rtl/lpt_enc_timer.sv
module lpt_enc_timer
  import lpt_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CW-1:0]     regWdata,
  output logic [CW-1:0]     regRdata,
  input  logic              inA,
  input  logic              inB
);
  dpCtl_t        dpCtl;
  logic [CW-1:0] limitVal, cntVal;
  logic          dirUp;
  logic [1:0]    okFlags;

  lpt_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cntVal(cntVal), .dirUp(dirUp),
    .regRdata(regRdata), .dpCtl(dpCtl), .limitVal(limitVal),
    .okFlags(okFlags)
  );

  lpt_datapath #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB), .dpCtl(dpCtl),
    .limitVal(limitVal), .cntVal(cntVal), .dirUp(dirUp)
  );
endmodule

// File: rtl/lpt_enc_timer_checker.sv
module lpt_enc_timer_checker
  import lpt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CW-1:0]     regWdata,
  input dpCtl_t            dpCtl,
  input logic [CW-1:0]     limitVal,
  input logic [CW-1:0]     cntVal,
  input logic              dirUp,
  input logic [1:0]        okFlags
);
  p_count_in_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.run |-> cntVal <= limitVal);

  p_disable_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.zero |=> cntVal == '0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.run && !dpCtl.zero) |=> $stable(cntVal));

  p_limit_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.run |=> $stable(limitVal));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (okFlags[0] && !(regWe && regAddr == ADDR_CLR && regWdata[0])) |=> okFlags[0]);

  p_setup_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.zero |=> ($stable(dpCtl.encMode) && $stable(dpCtl.edgeSel)));

  p_dir_plain_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.encMode |=> $stable(dirUp));
endmodule

bind lpt_enc_timer lpt_enc_timer_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .dpCtl(dpCtl), .limitVal(limitVal),
  .cntVal(cntVal), .dirUp(dirUp), .okFlags(okFlags)
);

// File: tb/lpt_enc_timer_test.sv
`timescale 1ns/1ps
module lpt_enc_timer_test;
  localparam logic [2:0] A_CTRL = 3'd0, A_SETUP = 3'd1, A_LIMIT = 3'd2,
                         A_CMP = 3'd3, A_STATUS = 3'd4, A_CLR = 3'd5,
                         A_COUNT = 3'd6;

  logic clk = 1'b0;
  logic rstN, regWe, inA, inB;
  logic [2:0] regAddr;
  logic [15:0] regWdata, regRdata;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpt_enc_timer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inA(inA), .inB(inB)
  );

  // vector: [23] encoder, [22:21] edge select, [20] reverse, [19:16] cycles, [15:0] expected count
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 4'd3, 16'd3},
    {1'b0, 2'd1, 1'b0, 4'd3, 16'd3},
    {1'b0, 2'd2, 1'b0, 4'd3, 16'd6},
    {1'b1, 2'd2, 1'b0, 4'd2, 16'd8},
    {1'b1, 2'd0, 1'b0, 4'd2, 16'd4},
    {1'b1, 2'd1, 1'b0, 4'd2, 16'd4},
    {1'b1, 2'd2, 1'b1, 4'd1, 16'hFFFC}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
    @(negedge clk);
  endtask

  task automatic setAB(input logic a, input logic b);
    inA = a; inB = b;
    idle(4);
  endtask

  task automatic plainPulse();
    setAB(1'b1, 1'b0); setAB(1'b0, 1'b0);
  endtask

  task automatic encFwd();
    setAB(1'b1, 1'b0); setAB(1'b1, 1'b1); setAB(1'b0, 1'b1); setAB(1'b0, 1'b0);
  endtask

  task automatic encRev();
    setAB(1'b0, 1'b1); setAB(1'b1, 1'b1); setAB(1'b1, 1'b0); setAB(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0; inA = 1'b0; inB = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_LIMIT, v);  check("R1 limit", v, 16'hFFFF);
    rd(A_COUNT, v);  check("R1 count", v, 16'h0000);
    rd(A_CMP, v);    check("R1 compare", v, 16'h0000);
    rd(A_STATUS, v); check("R1 status", v, 16'h0004);

    // table walk: R7 plain edges, R8 encoder resolution
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 16'h0000);
      wr(A_SETUP, {13'd0, VEC[i][22:21], VEC[i][23]});
      wr(A_CTRL, 16'h0001);
      wr(A_CTRL, 16'h0003);
      for (int c = 0; c < int'(VEC[i][19:16]); c++) begin
        if (!VEC[i][23])     plainPulse();
        else if (VEC[i][20]) encRev();
        else                 encFwd();
      end
      rd(A_COUNT, v);
      check(VEC[i][23] ? "R8 encoder count" : "R7 plain count", v, VEC[i][15:0]);
    end

    // R10 direction after reverse and after a forward step
    rd(A_STATUS, v); check("R10 dir down", {15'd0, v[2]}, 16'd0);
    setAB(1'b1, 1'b0);
    rd(A_STATUS, v); check("R10 dir up", {15'd0, v[2]}, 16'd1);
    rd(A_COUNT, v);  check("R9 count after up step", v, 16'hFFFD);
    setAB(1'b0, 1'b0);

    // R11 both phases changing together
    setAB(1'b1, 1'b1);
    rd(A_COUNT, v);  check("R11 illegal step", v, 16'hFFFC);
    setAB(1'b0, 1'b0);
    rd(A_COUNT, v);  check("R11 illegal step back", v, 16'hFFFC);

    // R6 setup locked while enabled
    wr(A_SETUP, 16'h0000);
    rd(A_SETUP, v);  check("R6 setup locked", v, 16'h0005);

    // R12 disable zeroes the count
    wr(A_CTRL, 16'h0000);
    idle(1);
    rd(A_COUNT, v);  check("R12 count zero", v, 16'h0000);
    rd(A_CTRL, v);   check("R12 ctrl idle", v, 16'h0000);

    // R2 loads ignored while disabled
    wr(A_LIMIT, 16'h0010);
    wr(A_CMP, 16'h0033);
    idle(2);
    rd(A_LIMIT, v);  check("R2 limit unchanged", v, 16'hFFFF);
    rd(A_CMP, v);    check("R2 compare unchanged", v, 16'h0000);
    rd(A_STATUS, v); check("R2 no flags", {14'd0, v[1:0]}, 16'd0);

    // R5 start in the enabling write does not run
    wr(A_CTRL, 16'h0003);
    rd(A_CTRL, v);   check("R5 enabled not running", v, 16'h0001);
    encFwd();
    rd(A_COUNT, v);  check("R5 idle count", v, 16'h0000);

    // R3 limit load handshake
    wr(A_LIMIT, 16'h0005);
    rd(A_STATUS, v); check("R3 flag pending", {15'd0, v[0]}, 16'd0);
    rd(A_LIMIT, v);  check("R3 limit landed", v, 16'h0005);
    rd(A_STATUS, v); check("R3 limit flag", {15'd0, v[0]}, 16'd1);
    wr(A_CMP, 16'h0022);
    idle(1);
    rd(A_CMP, v);    check("R3 compare landed", v, 16'h0022);
    rd(A_STATUS, v); check("R3 compare flag", {15'd0, v[1]}, 16'd1);

    // R4 selective clear, then clear colliding with a commit
    wr(A_CLR, 16'h0001);
    idle(1);
    rd(A_STATUS, v); check("R4 selective clear", {14'd0, v[1:0]}, 16'd2);
    wr(A_LIMIT, 16'h0005);
    wr(A_CLR, 16'h0001);
    idle(1);
    rd(A_STATUS, v); check("R4 set wins", {15'd0, v[0]}, 16'd1);
    wr(A_CLR, 16'h0003);
    idle(1);
    rd(A_STATUS, v); check("R4 clear both", {14'd0, v[1:0]}, 16'd0);

    // R9 wrap with limit 5, plain rising
    wr(A_CTRL, 16'h0000);
    wr(A_SETUP, 16'h0000);
    wr(A_CTRL, 16'h0001);
    wr(A_CTRL, 16'h0003);
    rd(A_CTRL, v);   check("R5 running", v, 16'h0003);
    for (int p = 0; p < 7; p++) plainPulse();
    rd(A_COUNT, v);  check("R9 wrap up", v, 16'h0001);

    // R3 limit locked while running
    wr(A_LIMIT, 16'h0009);
    idle(2);
    rd(A_LIMIT, v);  check("R3 locked limit", v, 16'h0005);
    rd(A_STATUS, v); check("R3 no flag while running", {15'd0, v[0]}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule